// File: doc/BRIEF.md
# SPI Target Receive Length-Capture Engine

This block is the receive half of an SPI target controller that carries host-command requests. It samples the serial line in SPI mode 0 (MOSI taken on the rising edge of SCLK, most significant bit first) while chip select is low. It stores each completed byte in a 256-byte receive FIFO, and the local CPU drains that FIFO one 32-bit word at a time.

As bytes arrive, a byte counter tracks their position in the frame. At a programmable byte offset the block captures a 16-bit little-endian request-length field. A valid-length status bit rises once the byte count reaches the larger of two values: a programmable target count, or the captured length plus the fixed header size. At that point the CPU knows the whole request is in the FIFO. A second status bit marks the end of a transaction when chip select returns high.

Software sees the block through a small byte-wide register interface. Through it, software programs the target count and the capture offset, masks the interrupts, clears the status bits and resets the FIFO.

Top module: `spi_rx_lencap`

## Requirements
- R1: Each group of 8 rising SCLK edges while CS_N is low forms one byte, first bit in bit 7. Bytes are stored in arrival order. `rd_data` presents the four oldest bytes little-endian: the oldest byte in bits 7:0 and the fourth in bits 31:24. A one-cycle `rd_en` pulse removes them.
- R2: The bytes at positions OFF and OFF+1 of the frame (position 0 is the first byte) are captured as `cap_len[7:0]` and `cap_len[15:8]`. OFF is written through register address 2 (low byte) and address 3 (high byte) and resets to 6.
- R3: Status bit 0 (valid length) sets once per transaction, when the byte count reaches max(TGT, cap_len + 8) and both length bytes have arrived. It is never set earlier. TGT is written through address 0 (low byte) and address 1 (high byte) and resets to 12.
- R4: When the FIFO holds 256 bytes, further bytes are dropped and the stored bytes are left unchanged. `rx_level` stays at 256 while `rx_count` keeps counting every arriving byte.
- R5: `irq` is high when any status bit is set while its mask bit is 0. The mask is at address 4, bit 0 for valid length and bit 1 for end of transaction, and it resets to all ones (both masked).
- R6: Writing address 5 clears each status bit whose write-data bit is 1 and leaves the other bits alone, so writing 0xFF clears all of them.
- R7: Writing address 6 with bit 0 set clears the FIFO pointers, the FIFO level, the byte count and the captured length by the next clock edge.
- R8: A rising edge of CS_N sets status bit 1 (end of transaction). If address 6 bit 1 is 1 (the reset value), the same edge also clears the FIFO, the byte count and the captured length. If that bit is 0, the stored data is kept.
- R9: An `rd_en` pulse while fewer than 4 bytes are stored is ignored, and `rx_level` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| rd_en | input | 1 | Pop one 32-bit word from the FIFO |
| rd_data | output | 32 | Oldest four FIFO bytes, little-endian |
| rx_level | output | 9 | Bytes currently stored |
| rx_count | output | 16 | Bytes received since the last clear |
| cap_len | output | 16 | Captured request length |
| int_sts | output | 2 | Status bits: valid length (bit 0), end of transaction (bit 1) |
| irq | output | 1 | Interrupt request |

## Verification
The bench places the valid-length threshold one byte away on both sides, with the target count winning in one test and the embedded length winning in another. A design that compared against only one of the two values, or used a strict inequality, would raise the status a byte early or a byte late. It moves the capture offset to catch a swapped or misplaced length byte. It also overfills the FIFO by four bytes and then reads out the final word, which shows whether a late byte overwrote stored data or whether the level wrapped to zero. Short reads and end-of-transaction handling with auto-clear off cover a design that pops an empty word or loses data on a chip-select edge it should ignore.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    typedef enum logic [2:0] {
        A_TGT_LO = 3'd0,
        A_TGT_HI = 3'd1,
        A_OFF_LO = 3'd2,
        A_OFF_HI = 3'd3,
        A_MASK   = 3'd4,
        A_STAT   = 3'd5,
        A_CTRL   = 3'd6
    } reg_addr_e;

    localparam int ST_VLEN = 0;
    localparam int ST_END  = 1;
    localparam int CNT_W   = 16;

    typedef struct packed {
        logic [CNT_W-1:0] tgt;
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [1:0]       mask;
        logic [1:0]       sts;
        logic             autorst;
        logic             len_ok;
        logic             hit;
    } ctl_t;

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    output logic sclk_rise,
    output logic cs_rise,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES:0] sclk_d, sclk_q;
    logic [STAGES:0] cs_d, cs_q;
    logic [STAGES-1:0] mosi_d, mosi_q;

    always_comb begin
        sclk_d = {sclk_q[STAGES-1:0], sclk};
        cs_d   = {cs_q[STAGES-1:0], cs_n};
        mosi_d = {mosi_q[STAGES-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= sclk_d;
            cs_q   <= cs_d;
            mosi_q <= mosi_d;
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign cs_rise   = cs_q[STAGES-1] & ~cs_q[STAGES];
    assign cs_act    = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              mosi_s,
    input  logic              clear,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] sr_d, sr_q;
    logic [BC_W-1:0]   bc_d, bc_q;
    logic              vld_d, vld_q;
    logic [BYTE_W-1:0] dat_d, dat_q;

    always_comb begin
        sr_d  = sr_q;
        bc_d  = bc_q;
        vld_d = 1'b0;
        dat_d = dat_q;
        if (clear) begin
            bc_d = '0;
        end else if (sample) begin
            sr_d = {sr_q[BYTE_W-3:0], mosi_s};
            bc_d = bc_q + 1'b1;
            if (bc_q == BC_W'(BYTE_W - 1)) begin
                vld_d = 1'b1;
                dat_d = {sr_q, mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            bc_q  <= '0;
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            sr_q  <= sr_d;
            bc_q  <= bc_d;
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign byte_vld  = vld_q;
    assign byte_data = dat_q;
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    input  logic                   rd_en,
    output logic [31:0]            rd_data,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [LW-1:0] lv_d, lv_q;
    logic          wr_ok, rd_ok;

    always_comb begin
        wr_ok = wr_en && (lv_q < LW'(DEPTH));
        rd_ok = rd_en && (lv_q >= LW'(4));
        wp_d  = wp_q;
        rp_d  = rp_q;
        lv_d  = lv_q;
        if (clr) begin
            wp_d = '0;
            rp_d = '0;
            lv_d = '0;
        end else begin
            if (wr_ok) wp_d = wp_q + 1'b1;
            if (rd_ok) rp_d = rp_q + AW'(4);
            lv_d = lv_q + (wr_ok ? LW'(1) : LW'(0)) - (rd_ok ? LW'(4) : LW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            lv_q <= '0;
        end else begin
            wp_q <= wp_d;
            rp_q <= rp_d;
            lv_q <= lv_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !clr) mem[wp_q] <= wr_data;
    end

    generate
        for (genvar i = 0; i < 4; i++) begin : g_lane
            assign rd_data[8*i +: 8] = mem[rp_q + AW'(i)];
        end
    endgenerate

    assign level = lv_q;

    // R4: a full FIFO stays full when a byte arrives without a read or clear
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_q == LW'(DEPTH) && wr_en && !rd_en && !clr) |=> (lv_q == LW'(DEPTH)));

    // R9: a pop with fewer than four bytes leaves the level unchanged
    p_short_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lv_q < LW'(4) && !wr_en && !clr) |=> $stable(lv_q));
endmodule

// File: rtl/spi_rx_lencap.sv
module spi_rx_lencap
    import spi_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    parameter int HDR_BYTES  = 8,
    parameter int LEN_OFS    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_mosi,
    input  logic                        spi_cs_n,
    input  logic                        reg_we,
    input  logic [2:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    input  logic                        rd_en,
    output logic [31:0]                 rd_data,
    output logic [$clog2(FIFO_DEPTH):0] rx_level,
    output logic [CNT_W-1:0]            rx_count,
    output logic [CNT_W-1:0]            cap_len,
    output logic [1:0]                  int_sts,
    output logic                        irq
);
    localparam logic [CNT_W-1:0] TGT_RST = CNT_W'(HDR_BYTES + 4);

    logic       sclk_rise, cs_rise, cs_act, mosi_s;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       soft_clr, fifo_clr, vlen_set;
    logic [CNT_W:0] need, thr;
    ctl_t       q, n;

    spi_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .sclk_rise(sclk_rise), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_rx_shift #(.BYTE_W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .sample(sclk_rise & cs_act), .mosi_s(mosi_s),
        .clear(~cs_act), .byte_vld(byte_vld), .byte_data(byte_data)
    );

    spi_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr_en(byte_vld), .wr_data(byte_data),
        .rd_en(rd_en), .rd_data(rd_data), .level(rx_level)
    );

    always_comb begin
        n        = q;
        soft_clr = reg_we && (reg_addr == A_CTRL) && reg_wdata[0];
        fifo_clr = soft_clr || (cs_rise && q.autorst);
        need     = {1'b0, q.len} + (CNT_W+1)'(HDR_BYTES);
        thr      = (need > {1'b0, q.tgt}) ? need : {1'b0, q.tgt};
        vlen_set = q.len_ok && !q.hit && ({1'b0, q.cnt} >= thr);

        if (reg_we) begin
            case (reg_addr)
                A_TGT_LO: n.tgt[7:0]  = reg_wdata;
                A_TGT_HI: n.tgt[15:8] = reg_wdata;
                A_OFF_LO: n.off[7:0]  = reg_wdata;
                A_OFF_HI: n.off[15:8] = reg_wdata;
                A_MASK:   n.mask      = reg_wdata[1:0];
                A_STAT:   n.sts       = q.sts & ~reg_wdata[1:0];
                A_CTRL:   n.autorst   = reg_wdata[1];
                default:  ;
            endcase
        end

        if (byte_vld) begin
            if (q.cnt != '1) n.cnt = q.cnt + 1'b1;
            if (q.cnt == q.off) n.len[7:0] = byte_data;
            if (q.cnt == q.off + 1'b1) begin
                n.len[15:8] = byte_data;
                n.len_ok    = 1'b1;
            end
        end

        if (vlen_set) begin
            n.sts[ST_VLEN] = 1'b1;
            n.hit          = 1'b1;
        end
        if (cs_rise) n.sts[ST_END] = 1'b1;

        if (fifo_clr) begin
            n.cnt    = '0;
            n.len    = '0;
            n.len_ok = 1'b0;
            n.hit    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.tgt     <= TGT_RST;
            q.off     <= CNT_W'(LEN_OFS);
            q.mask    <= 2'b11;
            q.autorst <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rx_count = q.cnt;
    assign cap_len  = q.len;
    assign int_sts  = q.sts;
    assign irq      = |(q.sts & ~q.mask);

    // R7: a software clear empties the FIFO and the counters by the next edge
    p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (rx_level == '0 && q.cnt == '0 && q.len == '0));

    // R6: writing ones to both status bits leaves them clear when no event lands
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STAT && reg_wdata[1:0] == 2'b11 && !vlen_set && !cs_rise)
        |=> (q.sts == 2'b00));

    // R3: valid length only rises after the whole length field was captured
    p_vlen_after_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sts[ST_VLEN]) |-> $past(q.len_ok));

    // R5: with both interrupts masked the request line stays low
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == 2'b11) |-> !irq);
endmodule

// File: tb/spi_rx_lencap_tb.sv
module spi_rx_lencap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [8:0]  rx_level;
    logic [15:0] rx_count, cap_len;
    logic [1:0]  int_sts;
    logic        irq;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    spi_rx_lencap u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_en(rd_en),
        .rd_data(rd_data), .rx_level(rx_level), .rx_count(rx_count), .cap_len(cap_len),
        .int_sts(int_sts), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        @(negedge clk);
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_low;
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_high;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic t_reset;
        check("R5 reset irq", {31'd0, irq}, 32'd0);
        check("R6 reset status", {30'd0, int_sts}, 32'd0);
        check("R1 reset level", {23'd0, rx_level}, 32'd0);
        check("R2 reset count", {16'd0, rx_count}, 32'd0);
    endtask

    task automatic t_target_wins;
        logic [7:0]  hdr [8] = '{8'h03, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'h02, 8'h00};
        logic [31:0] w;
        wr_reg(3'd4, 8'h00);
        cs_low();
        for (int i = 0; i < 11; i++) spi_byte(i < 8 ? hdr[i] : 8'h50 + 8'(i));
        wait_clk(10);
        check("R3 no valid length at 11 of 12 bytes", {30'd0, int_sts}, 32'd0);
        check("R2 captured length", {16'd0, cap_len}, 32'd2);
        spi_byte(8'h5B);
        wait_clk(10);
        check("R3 valid length at target count", {30'd0, int_sts}, 32'd1);
        check("R5 irq on unmasked status", {31'd0, irq}, 32'd1);
        pop(w);
        check("R1 first word little-endian", w, 32'hC3B2A103);
        check("R1 level after pop", {23'd0, rx_level}, 32'd8);
        cs_high();
        check("R8 end status set", {30'd0, int_sts}, 32'd3);
        check("R8 auto clear level", {23'd0, rx_level}, 32'd0);
        check("R8 auto clear count", {16'd0, rx_count}, 32'd0);
    endtask

    task automatic t_w1c;
        wr_reg(3'd5, 8'h01);
        check("R6 partial clear", {30'd0, int_sts}, 32'd2);
        check("R5 irq from end status", {31'd0, irq}, 32'd1);
        wr_reg(3'd5, 8'hFF);
        check("R6 clear all", {30'd0, int_sts}, 32'd0);
        check("R5 irq low after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_length_wins;
        cs_low();
        for (int i = 0; i < 27; i++) spi_byte(i == 6 ? 8'h14 : (i == 7 ? 8'h00 : 8'(i)));
        wait_clk(10);
        check("R3 no valid length at 27 of 28", {30'd0, int_sts}, 32'd0);
        spi_byte(8'h77);
        wait_clk(10);
        check("R3 valid length at length plus header", {30'd0, int_sts}, 32'd1);
        cs_high();
        wr_reg(3'd5, 8'hFF);
    endtask

    task automatic t_offset;
        logic [7:0] s [5] = '{8'h00, 8'h00, 8'h34, 8'h12, 8'h00};
        wr_reg(3'd2, 8'h02);
        wr_reg(3'd3, 8'h00);
        cs_low();
        for (int i = 0; i < 5; i++) spi_byte(s[i]);
        wait_clk(10);
        check("R2 capture at moved offset", {16'd0, cap_len}, 32'h1234);
        cs_high();
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd2, 8'h06);
    endtask

    task automatic t_mask;
        wr_reg(3'd4, 8'h03);
        cs_low();
        cs_high();
        check("R8 end status while masked", {30'd0, int_sts}, 32'd2);
        check("R5 masked irq low", {31'd0, irq}, 32'd0);
        wr_reg(3'd4, 8'h00);
        check("R5 unmask raises irq", {31'd0, irq}, 32'd1);
        wr_reg(3'd5, 8'hFF);
    endtask

    task automatic t_full;
        logic [31:0] w;
        wr_reg(3'd6, 8'h01);
        cs_low();
        for (int i = 0; i < 260; i++) spi_byte(8'(i));
        wait_clk(10);
        check("R4 level saturates", {23'd0, rx_level}, 32'd256);
        check("R4 count keeps counting", {16'd0, rx_count}, 32'd260);
        cs_high();
        check("R8 no auto clear when disabled", {23'd0, rx_level}, 32'd256);
        pop(w);
        check("R4 oldest word intact", w, 32'h03020100);
        for (int i = 1; i < 63; i++) pop(w);
        pop(w);
        check("R4 last word not overwritten", w, 32'hFFFEFDFC);
        check("R4 drained", {23'd0, rx_level}, 32'd0);
        wr_reg(3'd5, 8'hFF);
    endtask

    task automatic t_soft_and_short;
        logic [31:0] w;
        wr_reg(3'd6, 8'h03);
        cs_low();
        for (int i = 0; i < 8; i++) spi_byte(i == 6 ? 8'h05 : 8'h00);
        wait_clk(10);
        check("R2 length before clear", {16'd0, cap_len}, 32'd5);
        wr_reg(3'd6, 8'h03);
        check("R7 level cleared", {23'd0, rx_level}, 32'd0);
        check("R7 count cleared", {16'd0, rx_count}, 32'd0);
        check("R7 length cleared", {16'd0, cap_len}, 32'd0);
        spi_byte(8'hAA);
        spi_byte(8'hBB);
        wait_clk(10);
        pop(w);
        check("R9 short pop ignored", {23'd0, rx_level}, 32'd2);
        cs_high();
        check("R8 auto clear restored", {23'd0, rx_level}, 32'd0);
        wr_reg(3'd5, 8'hFF);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_target_wins();
        t_w1c();
        t_length_wins();
        t_offset();
        t_mask();
        t_full();
        t_soft_and_short();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule